// File: doc/BRIEF.md
# MSB-first scalar bit walker

This block feeds a double-and-add or square-and-multiply controller with the bits of a 32-bit scalar. The walk runs from the most significant set bit down to bit 0. When a start pulse arrives while the block is idle, it captures the scalar. In the same cycle, a priority decode finds the highest set bit. The block then offers one bit per step on a valid/ready handshake. Each step carries a flag for the first bit and a flag for the last bit, so the caller can skip the opening double and knows when the result is final. Leading zeros are never offered.

The end of the walk is tracked by a one-hot marker register rather than a step counter. The marker is loaded with a single 1 at the position of the highest set bit and moves down one place on each accepted step. The bit offered at each step is the captured scalar masked by the marker and then OR-reduced. The walk is over when the marker shifts out of bit 0. A scalar of zero produces no steps and reports completion at once.

Top module: `msb_bit_walker`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, step_valid_o and done_o are 0.
- R2: A start with a zero scalar raises done_o in the cycle after start and never raises step_valid_o.
- R3: A start with a nonzero scalar raises step_valid_o in the cycle after start. That first step has step_first_o = 1 and step_bit_o = 1, which is the highest set bit. All later steps have step_first_o = 0.
- R4: The number of steps equals the index of the highest set bit plus one. The bits appear from that index down to bit 0, so a scalar of 17 gives 1,0,0,0,1.
- R5: step_last_o is 1 only on the step that carries bit 0.
- R6: A step completes only on a cycle where step_valid_o and step_ready_i are both 1. While step_ready_i is 0, step_valid_o, step_bit_o, step_first_o and step_last_o hold their values.
- R7: done_o is a one-cycle pulse, raised in the cycle after the last step completes. step_valid_o is 0 from then on, and the block is idle in the following cycle.
- R8: A start that arrives while a walk is under way, or in the done cycle, is ignored. The walk in progress keeps its scalar, and no new walk begins.
- R9: A scalar with bit 31 set gives exactly 32 steps, followed by done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a walk over scalar_i (honoured only when idle) |
| scalar_i | input | 32 | Scalar to walk, sampled together with start_i |
| step_ready_i | input | 1 | Caller accepts the bit being offered |
| step_valid_o | output | 1 | A bit is being offered |
| step_bit_o | output | 1 | Value of the offered bit |
| step_first_o | output | 1 | The offered bit is the highest set bit |
| step_last_o | output | 1 | The offered bit is bit 0 |
| done_o | output | 1 | One-cycle pulse when the walk has finished |

## Verification
A marker that is not one-hot, or that sits in the wrong place, shows up on the very next offered step: step_bit_o disagrees with the scalar bit the bench expects, or step_last_o appears early or late. A wrong state shows up within one cycle of start or of the final handshake, as a missing done_o, an extra valid step or a lost stall. A scalar overwritten by an ignored start corrupts the next offered bit. The bench therefore compares every step of several scalars, with and without stalls, against the bits taken straight from the scalar.

// File: rtl/bitwalk_pkg.sv
package bitwalk_pkg;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_STEP = 2'd1,
        WK_DONE = 2'd2
    } walk_state_e;

endpackage

// File: rtl/bw_lead_one.sv
// Priority decode: one-hot of the highest set bit; the top bit wins.
module bw_lead_one #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] top_o,
    output logic         any_o
);

    logic seen_v;

    always_comb begin
        seen_v = 1'b0;
        top_o  = '0;
        for (int i = W - 1; i >= 0; i--) begin
            top_o[i] = vec_i[i] & ~seen_v;
            seen_v   = seen_v | vec_i[i];
        end
    end

    assign any_o = |vec_i;

    // R3
    always_comb begin
        if (!$isunknown(vec_i)) begin
            lead_onehot_chk: assert ($onehot0(top_o) && ((|top_o) == any_o));
        end
    end

endmodule

// File: rtl/bw_bit_pick.sv
// Select one bit of a word by a one-hot mask.
module bw_bit_pick #(
    parameter int W = 32
) (
    input  logic [W-1:0] word_i,
    input  logic [W-1:0] sel_i,
    output logic         bit_o
);

    assign bit_o = |(word_i & sel_i);

endmodule

// File: rtl/msb_bit_walker.sv
module msb_bit_walker
    import bitwalk_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] scalar_i,
    input  logic             step_ready_i,
    output logic             step_valid_o,
    output logic             step_bit_o,
    output logic             step_first_o,
    output logic             step_last_o,
    output logic             done_o
);

    typedef struct packed {
        walk_state_e      state;
        logic [WIDTH-1:0] word;
        logic [WIDTH-1:0] mark;
        logic             first;
    } walk_regs_t;

    walk_regs_t       reg_d, reg_q;
    logic [WIDTH-1:0] top_hot;
    logic             scalar_nz;
    logic             picked;

    bw_lead_one #(.W(WIDTH)) i_lead (
        .vec_i (scalar_i),
        .top_o (top_hot),
        .any_o (scalar_nz)
    );

    bw_bit_pick #(.W(WIDTH)) i_pick (
        .word_i (reg_q.word),
        .sel_i  (reg_q.mark),
        .bit_o  (picked)
    );

    always_comb begin
        reg_d = reg_q;
        unique case (reg_q.state)
            WK_IDLE: begin
                if (start_i) begin
                    reg_d.word  = scalar_i;
                    reg_d.mark  = top_hot;
                    reg_d.first = 1'b1;
                    reg_d.state = scalar_nz ? WK_STEP : WK_DONE;
                end
            end
            WK_STEP: begin
                if (step_ready_i) begin
                    reg_d.mark  = reg_q.mark >> 1;
                    reg_d.first = 1'b0;
                    if (reg_q.mark[0]) begin
                        reg_d.state = WK_DONE;
                    end
                end
            end
            WK_DONE: begin
                reg_d.state = WK_IDLE;
            end
            default: begin
                reg_d.state = WK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            reg_q.state <= WK_IDLE;
            reg_q.word  <= '0;
            reg_q.mark  <= '0;
            reg_q.first <= 1'b0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign step_valid_o = (reg_q.state == WK_STEP);
    assign step_bit_o   = picked;
    assign step_first_o = step_valid_o & reg_q.first;
    assign step_last_o  = step_valid_o & reg_q.mark[0];
    assign done_o       = (reg_q.state == WK_DONE);

    // R2
    zero_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_q.state == WK_IDLE && start_i && scalar_i == '0) |=> (done_o && !step_valid_o));

    // R3
    first_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_q.state == WK_IDLE && start_i && scalar_i != '0)
        |=> (step_valid_o && step_first_o && step_bit_o));

    // R4
    marker_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_valid_o |-> $onehot(reg_q.mark));

    // R6
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_valid_o && !step_ready_i)
        |=> (step_valid_o && $stable(step_bit_o) && $stable(step_first_o) && $stable(step_last_o)));

    // R7
    last_to_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_valid_o && step_ready_i && step_last_o) |=> (done_o && !step_valid_o));

    // R7
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8
    busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_q.state != WK_IDLE && start_i) |=> $stable(reg_q.word));

endmodule

// File: tb/test_msb_bit_walker.sv
module test_msb_bit_walker;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W  = 32;
    localparam int NV = 8;
    localparam logic [W-1:0] VEC [NV] = '{32'd17, 32'd1, 32'h8000_0000, 32'hFFFF_FFFF,
                                          32'h0001_0000, 32'hA5A5_0F0F, 32'd2, 32'h4000_0001};
    localparam int LEN [NV] = '{5, 1, 32, 32, 17, 32, 2, 31};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ready = 1'b0;
    logic [W-1:0] scalar = '0;
    logic valid, bit_o, first, last, done;
    int n_cmp = 0, n_bad = 0, stall_ctr = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    msb_bit_walker #(.WIDTH(W)) i_msb_bit_walker (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scalar_i(scalar),
        .step_ready_i(ready), .step_valid_o(valid), .step_bit_o(bit_o),
        .step_first_o(first), .step_last_o(last), .done_o(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called and returns just after a falling edge.
    task automatic walk(input logic [W-1:0] v, input int len, input bit stall);
        int k;
        bit held;
        logic hold_bit;
        held = 1'b0;
        hold_bit = 1'b0;
        start = 1'b1; scalar = v;
        @(negedge clk);
        start = 1'b0; scalar = '0;
        if (len == 0) begin
            chk("R2", "done after zero start", done, 1);
            chk("R2", "no valid on zero", valid, 0);
            @(negedge clk);
            chk("R7", "done drops", done, 0);
            chk("R2", "still no valid", valid, 0);
            return;
        end
        chk("R3", "valid after start", valid, 1);
        k = len - 1;
        while (k >= 0) begin
            chk("R6", "valid kept", valid, 1);
            if (held) chk("R6", "bit held over stall", bit_o, hold_bit);
            ready = stall ? ((stall_ctr % 3) != 0) : 1'b1;
            stall_ctr++;
            if (ready) begin
                chk("R4", "bit value", bit_o, v[k]);
                chk("R3", "first flag", first, (k == len - 1));
                chk("R5", "last flag", last, (k == 0));
                held = 1'b0;
                k--;
            end else begin
                held = 1'b1;
                hold_bit = bit_o;
            end
            @(negedge clk);
        end
        ready = 1'b0;
        chk((len == W) ? "R9" : "R7", "done after final step", done, 1);
        chk("R7", "valid off at done", valid, 0);
        @(negedge clk);
        chk("R7", "done is one cycle", done, 0);
        chk("R7", "idle after done", valid, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1", "valid in reset", valid, 0);
        chk("R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", valid, 0);
        chk("R1", "done after reset", done, 0);

        for (int i = 0; i < NV; i++) begin
            walk(VEC[i], LEN[i], (i % 2) == 1);
        end

        walk('0, 0, 1'b0);

        // R8: starts during a walk and during the done cycle are ignored
        start = 1'b1; scalar = 32'd5;
        @(negedge clk);
        start = 1'b0; ready = 1'b1;
        chk("R8", "bit2 of 5", bit_o, 1);
        @(negedge clk);
        start = 1'b1; scalar = 32'hFFFF_FFFF; ready = 1'b0;
        chk("R8", "bit1 of 5", bit_o, 0);
        @(negedge clk);
        start = 1'b0;
        chk("R8", "walk continues", valid, 1);
        chk("R8", "bit1 kept after busy start", bit_o, 0);
        chk("R8", "not restarted", first, 0);
        ready = 1'b1;
        @(negedge clk);
        chk("R8", "bit0 of 5", bit_o, 1);
        chk("R5", "last on bit0", last, 1);
        @(negedge clk);
        ready = 1'b0;
        chk("R7", "done after 5", done, 1);
        start = 1'b1; scalar = 32'd3;
        @(negedge clk);
        start = 1'b0; scalar = '0;
        chk("R8", "start in done cycle ignored", valid, 0);
        chk("R8", "no second done", done, 0);
        @(negedge clk);
        chk("R8", "still idle", valid, 0);

        walk(32'd17, 5, 1'b1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule